// File: doc/BRIEF.md
# Sub-audio Detect Dropout Hold Timer

This block turns a raw, sample-by-sample "sub-audio present" flag into a steady detect output. Time is counted in ticks of a 1 ms enable pulse. While nothing is detected, the output goes high on the first tick that sees the raw flag high. Once the output is high, short gaps in the raw flag are bridged. Loss is declared only after the flag has stayed low for a run of consecutive ticks equal to a programmable hold time plus a fixed 40 ms de-response margin.

The hold time comes from a 4-bit selector in 8 ms units, so it covers 0 to 120 ms. The full absence needed before loss is therefore `sel*8 + 40` ticks, from 40 to 160 ticks. Alongside the level output, the block gives a one-cycle pulse when detection starts and another when loss is declared. These let a controller react to edges without keeping its own edge detector. No data stream enters or leaves the block, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `subaudio_hold`

## Requirements
- R1: While `rst_n` is low and on the cycle after it is released, `detected`, `det_start` and `det_lost` are 0 and the absence count is cleared.
- R2: When `detected` is 0 and a clock edge sees `tick`=1 with `raw_present`=1, `detected` reads 1 after that edge and `det_start` is 1 for exactly that one cycle.
- R3: On clock edges where `tick`=0, `detected` does not change and neither pulse is raised, whatever `raw_present` and `hold_sel` do.
- R4: While `detected` is 1, loss is declared on the tick that completes `hold_sel*8 + 40` consecutive ticks with `raw_present`=0. `hold_sel` is an unsigned 4-bit value from 0 to 15.
- R5: A run of fewer absent ticks than that limit, followed by a tick with `raw_present`=1, leaves `detected` at 1 and restarts the absence count from zero.
- R6: When loss is declared, `detected` reads 0 after that edge and `det_lost` is 1 for exactly that one cycle.
- R7: With `hold_sel`=0, loss needs exactly 40 consecutive absent ticks.
- R8: `det_start` and `det_lost` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 ms timing enable |
| raw_present | input | 1 | Raw sub-audio present flag |
| hold_sel | input | 4 | Dropout hold time in 8 ms steps |
| detected | output | 1 | Filtered detect level |
| det_start | output | 1 | One-cycle pulse when detection begins |
| det_lost | output | 1 | One-cycle pulse when loss is declared |

## Verification
The absence count is the only internal state apart from the detect flag, and a wrong count shows up only as a loss edge on the wrong tick. Loss can come early after a tolerated gap that should have cleared the count, or late or never at the upper end of the limit. The bench sweeps every `hold_sel` value and counts ticks up to the loss pulse, so a miscount by a single tick is seen on the first hold cycle of that setting. A gap one tick short of the limit followed by a return of the flag then proves that recovery clears the count.

// File: rtl/sah_pkg.sv
package sah_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } sah_state_e;

  function automatic int unsigned sah_max_limit(input int unsigned sel_w,
                                                 input int unsigned step,
                                                 input int unsigned extra);
    return ((2 ** sel_w) - 1) * step + extra;
  endfunction
endpackage

// File: rtl/sah_limit.sv
module sah_limit #(
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned STEP_TICKS  = 8,
  parameter int unsigned EXTRA_TICKS = 40,
  parameter int unsigned CNT_W       = 8
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] limit
);
  localparam logic [CNT_W-1:0] STEP_C  = CNT_W'(STEP_TICKS);
  localparam logic [CNT_W-1:0] EXTRA_C = CNT_W'(EXTRA_TICKS);

  logic [CNT_W-1:0] sel_ext;

  always_comb begin
    sel_ext = CNT_W'(sel);
    limit   = sel_ext * STEP_C + EXTRA_C;
  end
endmodule

// File: rtl/sah_gap_cnt.sv
module sah_gap_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             raw,
  input  logic             armed,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_inc;
  logic             absent_tick;

  always_comb begin
    count_inc   = count + 1'b1;
    absent_tick = tick && armed && !raw;
    expire      = absent_tick && (count_inc >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!armed || expire || (tick && raw)) begin
      count <= '0;
    end else if (absent_tick) begin
      count <= count_inc;
    end
  end
endmodule

// File: rtl/sah_state.sv
module sah_state
  import sah_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  input  logic expire,
  output logic held,
  output logic start_pulse,
  output logic lost_pulse
);
  sah_state_e state_q, state_d;
  logic       start_d, lost_d;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    lost_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick && raw) begin
          state_d = ST_HELD;
          start_d = 1'b1;
        end
      end
      ST_HELD: begin
        if (expire) begin
          state_d = ST_IDLE;
          lost_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      start_pulse <= 1'b0;
      lost_pulse  <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_pulse <= start_d;
      lost_pulse  <= lost_d;
    end
  end

  assign held = (state_q == ST_HELD);
endmodule

// File: rtl/subaudio_hold.sv
module subaudio_hold
  import sah_pkg::*;
#(
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned STEP_TICKS  = 8,
  parameter int unsigned EXTRA_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             raw_present,
  input  logic [SEL_W-1:0] hold_sel,
  output logic             detected,
  output logic             det_start,
  output logic             det_lost
);
  localparam int unsigned MAX_LIMIT = sah_max_limit(SEL_W, STEP_TICKS, EXTRA_TICKS);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] gap_limit;
  logic [CNT_W-1:0] gap_count;
  logic             gap_expire;
  logic             held;

  sah_limit #(
    .SEL_W      (SEL_W),
    .STEP_TICKS (STEP_TICKS),
    .EXTRA_TICKS(EXTRA_TICKS),
    .CNT_W      (CNT_W)
  ) u_limit (
    .sel  (hold_sel),
    .limit(gap_limit)
  );

  sah_gap_cnt #(
    .CNT_W(CNT_W)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .raw   (raw_present),
    .armed (held),
    .limit (gap_limit),
    .count (gap_count),
    .expire(gap_expire)
  );

  sah_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .raw        (raw_present),
    .expire     (gap_expire),
    .held       (held),
    .start_pulse(det_start),
    .lost_pulse (det_lost)
  );

  assign detected = held;
endmodule

// File: rtl/sah_checker.sv
module sah_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             raw_present,
  input logic             detected,
  input logic             det_start,
  input logic             det_lost,
  input logic [CNT_W-1:0] gap_count,
  input logic [CNT_W-1:0] gap_limit
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(!rst_n) && past_ok == 1'b0 |-> !detected && !det_start && !det_lost && gap_count == '0);

  p_start_marks_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(detected) |-> det_start);

  p_start_with_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |-> detected);

  p_idle_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !tick |=> $stable(detected) && !det_start && !det_lost);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    detected |-> gap_count < gap_limit);

  p_return_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && tick && raw_present && detected |=> detected && gap_count == '0);

  p_loss_marks_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(detected) |-> det_lost);

  p_loss_with_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_lost |-> !detected);

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_start && det_lost));
endmodule

bind subaudio_hold sah_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .raw_present(raw_present),
  .detected   (detected),
  .det_start  (det_start),
  .det_lost   (det_lost),
  .gap_count  (gap_count),
  .gap_limit  (gap_limit)
);

// File: tb/sim_subaudio_hold.sv
`timescale 1ns/1ps
module sim_subaudio_hold;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       raw_present = 1'b0;
  logic [3:0] hold_sel = 4'd0;
  logic       detected, det_start, det_lost;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  subaudio_hold u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_present(raw_present),
    .hold_sel(hold_sel), .detected(detected), .det_start(det_start), .det_lost(det_lost)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, leave outputs to sample at next negedge
  task automatic step(input bit t, input bit r);
    @(negedge clk);
    tick = t;
    raw_present = r;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_out(input string req, input int d, input int s, input int l);
    chk(req, "detected", int'(detected), d);
    chk(req, "det_start", int'(det_start), s);
    chk(req, "det_lost", int'(det_lost), l);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    raw_present = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 0, 0, 0);
  endtask

  initial begin
    do_reset();

    // R3: raw high without any tick must not assert
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      raw_present = 1'b1;
      hold_sel = 4'(i);
      @(negedge clk);
      check_out("R3", 0, 0, 0);
    end

    // R2: first tick with raw high asserts, pulse lasts one cycle
    hold_sel = 4'd0;
    step(1'b1, 1'b1);
    check_out("R2", 1, 1, 0);
    @(negedge clk);
    check_out("R2", 1, 0, 0);

    // R3: raw low without ticks for long time keeps detected
    raw_present = 1'b0;
    repeat (300) @(negedge clk);
    check_out("R3", 1, 0, 0);

    // sweep every hold setting
    for (int sel = 0; sel < 16; sel++) begin
      int lim;
      int n;
      string rq;
      lim = sel * 8 + 40;
      rq = (sel == 0) ? "R7" : "R4";
      hold_sel = 4'(sel);
      if (!detected) begin
        step(1'b1, 1'b1);
        check_out("R2", 1, 1, 0);
      end
      // R5: gap of lim-1 ticks then return, stays detected
      for (int g = 0; g < lim - 1; g++) begin
        step(1'b1, 1'b0);
        if (det_lost || !detected) begin
          check_out("R5", 1, 0, 0);
          break;
        end
      end
      step(1'b1, 1'b1);
      check_out("R5", 1, 0, 0);
      // interleave non-tick cycles with raw low: must not count (R3)
      raw_present = 1'b0;
      repeat (20) @(negedge clk);
      check_out("R3", 1, 0, 0);
      // R4/R7: count absent ticks until loss
      n = 0;
      for (int g = 0; g < 200; g++) begin
        step(1'b1, 1'b0);
        n++;
        if (det_lost) break;
      end
      chk(rq, "ticks to loss", n, lim);
      check_out("R6", 0, 0, 1);
      @(negedge clk);
      check_out("R6", 0, 0, 0);
      // R8: re-assert immediately on next tick
      step(1'b1, 1'b1);
      check_out("R8", 1, 1, 0);
    end

    // R1: reset while detected clears it
    do_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule